// File: doc/BRIEF.md
# Delayed Branch and Loop-Count Unit

This block sequences the program counter of a 32-bit RISC core. The core architecture has one optional delay slot per branch. On each cycle that `instr_valid` is high, the block takes in the instruction sitting at its own PC, the two register operands and the condition-code bit. It then decides the next PC. Any return address for register 1 appears on the link write port. A loop instruction writes its sum back to its second source register and updates the stored loop bit.

The block has a two-state machine. State `ST_SEQ` means the current instruction is an ordinary one. State `ST_SLOT` means the current instruction sits in the delay slot of a taken branch, and the branch target is parked in a pending register.

The transitions are:
- **seq→slot**: a taken branch that has a delay slot.
- **seq→seq**: a taken branch without a slot, or any other instruction.
- **slot→seq**: always on a valid cycle. The PC goes to the pending target, unless the slot instruction is itself a taken branch. In that case its own target wins and its own slot is not honoured.

A cycle with `instr_valid` low leaves all state untouched.

Top module: `dbr_unit`

## Requirements
- R1: After reset `pc_out` equals parameter `RESET_PC` (default 0x0000_1000), and `slot_active` and `loop_bit` are 0.
- R2: A valid instruction that is not a taken branch, executing in `ST_SEQ`, moves the PC to PC+4. The opcode is `instr[31:26]`.
- R3: Opcode 0x1A (jump) and opcode 0x1B (call) always branch to PC + 4 + 4·sext(`instr[25:0]`), with a delay slot.
- R4: Opcode 0x1B, and opcode 0x13 with `instr[4:0]`=2 (indirect call), raise `link_we` with `link_data` = PC+8.
- R5: Opcode 0x10 (indirect jump) and the indirect call branch to `rs1_val`, with a delay slot.
- R6: Opcodes 0x1C/0x1D branch when `cc_in`=1, and 0x1E/0x1F branch when `cc_in`=0. The even opcodes have no slot and the odd ones have a slot. The target is formed as in R3. When the condition fails, the PC moves to PC+4 and no slot follows.
- R7: Opcodes 0x14/0x15 branch when the operands differ, and 0x16/0x17 branch when they are equal. Neither has a slot. The first operand is `instr[15:11]` zero-extended for the odd opcodes and `rs1_val` for the even ones. The second operand is `rs2_val`. The target is PC + 4 + 4·sext({`instr[20:16]`,`instr[10:0]`}).
- R8: A taken slotted branch sends the PC to PC+4 and raises `slot_active` for the next instruction. After that instruction the PC moves to the target.
- R9: A taken branch executing in the delay slot sends the PC straight to its own target. The pending target is dropped and no further slot is entered.
- R10: Opcode 0x2D (loop) raises `loop_we` with `loop_data` = `rs1_val`+`rs2_val`. It is taken, with a slot, to the R7-style target exactly when `loop_bit` was 1 before the instruction.
- R11: After a loop instruction, `loop_bit` takes a new value that depends on the sign of `rs1_val`. If `rs1_val` is negative, `loop_bit` is 1 when bit 31 of the 32-bit sum is 0. Otherwise `loop_bit` is the unsigned carry out of the addition. For example, −1 plus −1 yields 0.
- R12: While `instr_valid` is 0, `pc_out`, `slot_active` and `loop_bit` hold, `next_pc` equals `pc_out`, and both write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction at `pc_out` executes this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value |
| cc_in | input | 1 | Condition-code bit |
| pc_out | output | 32 | PC of the current instruction |
| next_pc | output | 32 | PC that will be loaded at the next edge |
| slot_active | output | 1 | Current instruction is a delay slot |
| link_we | output | 1 | Write return address to register 1 |
| link_data | output | 32 | Return address (PC+8) |
| loop_we | output | 1 | Write loop sum back to source 2 |
| loop_data | output | 32 | Loop sum |
| loop_bit | output | 1 | Stored loop-condition bit |

## Verification
The hardest situation to reach is a taken branch inside a delay slot, especially a loop instruction there. Reaching it needs a slotted branch that is taken, followed on the very next valid cycle by a second branch whose condition holds. For the loop case, `loop_bit` must already be 1 from an earlier loop instruction. The stimulus builds these chains directly: it primes `loop_bit` with a carry-producing loop instruction, then places the override branch in the slot. A behavioural model runs alongside and tracks the pending target independently.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    localparam int XLEN = 32;
    localparam int OPW  = 6;

    localparam logic [OPW-1:0] OP_JMP_IND  = 6'h10;
    localparam logic [OPW-1:0] OP_ESCAPE   = 6'h13;
    localparam logic [OPW-1:0] OP_CMP_NE_R = 6'h14;
    localparam logic [OPW-1:0] OP_CMP_NE_K = 6'h15;
    localparam logic [OPW-1:0] OP_CMP_EQ_R = 6'h16;
    localparam logic [OPW-1:0] OP_CMP_EQ_K = 6'h17;
    localparam logic [OPW-1:0] OP_JMP      = 6'h1A;
    localparam logic [OPW-1:0] OP_CALL     = 6'h1B;
    localparam logic [OPW-1:0] OP_IFCC     = 6'h1C;
    localparam logic [OPW-1:0] OP_IFCC_S   = 6'h1D;
    localparam logic [OPW-1:0] OP_IFNCC    = 6'h1E;
    localparam logic [OPW-1:0] OP_IFNCC_S  = 6'h1F;
    localparam logic [OPW-1:0] OP_LOOP     = 6'h2D;
    localparam logic [4:0]     ESC_CALLI   = 5'h02;

    typedef enum logic [2:0] {
        K_NONE, K_DIRECT, K_INDIRECT, K_IFCC, K_IFNCC, K_CMP_NE, K_CMP_EQ, K_LOOP
    } br_kind_t;

    typedef enum logic {
        ST_SEQ,
        ST_SLOT
    } seq_state_t;
endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
    import dbr_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output br_kind_t        kind,
    output logic            has_slot,
    output logic            writes_link,
    output logic            use_const,
    output logic [4:0]      const5,
    output logic [XLEN-1:0] byte_off
);
    localparam int LONGW  = 26;
    localparam int SHORTW = 16;

    logic [OPW-1:0]    op;
    logic [SHORTW-1:0] split_off;
    logic [XLEN-1:0]   off_long;
    logic [XLEN-1:0]   off_short;

    assign op        = instr[31:26];
    assign split_off = {instr[20:16], instr[10:0]};
    assign off_long  = {{(XLEN-LONGW-2){instr[LONGW-1]}}, instr[LONGW-1:0], 2'b00};
    assign off_short = {{(XLEN-SHORTW-2){split_off[SHORTW-1]}}, split_off, 2'b00};
    assign const5    = instr[15:11];

    always_comb begin
        kind        = K_NONE;
        has_slot    = 1'b0;
        writes_link = 1'b0;
        use_const   = 1'b0;
        byte_off    = off_short;
        unique case (op)
            OP_JMP_IND: begin
                kind     = K_INDIRECT;
                has_slot = 1'b1;
            end
            OP_ESCAPE: begin
                if (instr[4:0] == ESC_CALLI) begin
                    kind        = K_INDIRECT;
                    has_slot    = 1'b1;
                    writes_link = 1'b1;
                end
            end
            OP_JMP, OP_CALL: begin
                kind        = K_DIRECT;
                has_slot    = 1'b1;
                writes_link = op[0];
                byte_off    = off_long;
            end
            OP_IFCC, OP_IFCC_S: begin
                kind     = K_IFCC;
                has_slot = op[0];
                byte_off = off_long;
            end
            OP_IFNCC, OP_IFNCC_S: begin
                kind     = K_IFNCC;
                has_slot = op[0];
                byte_off = off_long;
            end
            OP_CMP_NE_R, OP_CMP_NE_K: begin
                kind      = K_CMP_NE;
                use_const = op[0];
            end
            OP_CMP_EQ_R, OP_CMP_EQ_K: begin
                kind      = K_CMP_EQ;
                use_const = op[0];
            end
            OP_LOOP: begin
                kind     = K_LOOP;
                has_slot = 1'b1;
            end
            default: kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/dbr_loopcalc.sv
module dbr_loopcalc
    import dbr_pkg::*;
(
    input  logic [XLEN-1:0] step_val,
    input  logic [XLEN-1:0] count_val,
    output logic [XLEN-1:0] sum,
    output logic            cond_next
);
    logic [XLEN:0] wide;

    assign wide = {1'b0, step_val} + {1'b0, count_val};
    assign sum  = wide[XLEN-1:0];

    always_comb begin
        if (step_val[XLEN-1])
            cond_next = ~wide[XLEN-1];
        else
            cond_next = wide[XLEN];
    end

    always_comb begin
        if (step_val == '1 && count_val == '1)
            assert (cond_next == 1'b0)
                else $error("AST_SPENT_COUNT_STOPS failed"); // R11
    end
endmodule

// File: rtl/dbr_unit.sv
module dbr_unit
    import dbr_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic            cc_in,
    output logic [XLEN-1:0] pc_out,
    output logic [XLEN-1:0] next_pc,
    output logic            slot_active,
    output logic            link_we,
    output logic [XLEN-1:0] link_data,
    output logic            loop_we,
    output logic [XLEN-1:0] loop_data,
    output logic            loop_bit
);
    localparam logic [XLEN-1:0] INSTR_BYTES = 4;

    seq_state_t      state_q, state_d;
    logic [XLEN-1:0] pc_q, pc_d;
    logic [XLEN-1:0] pend_q, pend_d;
    logic            lcc_q, lcc_d;

    br_kind_t        kind;
    logic            has_slot, writes_link, use_const;
    logic [4:0]      const5;
    logic [XLEN-1:0] byte_off;
    logic [XLEN-1:0] lhs, target, seq_pc, sum;
    logic            taken, lcc_new;

    dbr_decode u_decode (
        .instr       (instr),
        .kind        (kind),
        .has_slot    (has_slot),
        .writes_link (writes_link),
        .use_const   (use_const),
        .const5      (const5),
        .byte_off    (byte_off)
    );

    dbr_loopcalc u_loop (
        .step_val  (rs1_val),
        .count_val (rs2_val),
        .sum       (sum),
        .cond_next (lcc_new)
    );

    assign seq_pc = pc_q + INSTR_BYTES;
    assign lhs    = use_const ? {{(XLEN-5){1'b0}}, const5} : rs1_val;
    assign target = (kind == K_INDIRECT) ? rs1_val : seq_pc + byte_off;

    always_comb begin
        unique case (kind)
            K_DIRECT, K_INDIRECT: taken = 1'b1;
            K_IFCC:               taken = cc_in;
            K_IFNCC:              taken = ~cc_in;
            K_CMP_NE:             taken = (lhs != rs2_val);
            K_CMP_EQ:             taken = (lhs == rs2_val);
            K_LOOP:               taken = lcc_q;
            default:              taken = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEQ;
            pc_q    <= RESET_PC;
            pend_q  <= RESET_PC;
            lcc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            pend_q  <= pend_d;
            lcc_q   <= lcc_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        pend_d  = pend_q;
        lcc_d   = lcc_q;
        if (instr_valid) begin
            unique case (state_q)
                ST_SEQ: begin
                    if (taken && has_slot) begin
                        pc_d    = seq_pc;
                        pend_d  = target;
                        state_d = ST_SLOT;
                    end else if (taken) begin
                        pc_d = target;
                    end else begin
                        pc_d = seq_pc;
                    end
                end
                ST_SLOT: begin
                    pc_d    = taken ? target : pend_q;
                    state_d = ST_SEQ;
                end
                default: state_d = ST_SEQ;
            endcase
            if (kind == K_LOOP)
                lcc_d = lcc_new;
        end
    end

    // outputs
    always_comb begin
        pc_out      = pc_q;
        next_pc     = pc_d;
        slot_active = (state_q == ST_SLOT);
        link_we     = instr_valid && writes_link;
        link_data   = pc_q + 2 * INSTR_BYTES;
        loop_we     = instr_valid && (kind == K_LOOP);
        loop_data   = sum;
        loop_bit    = lcc_q;
    end

    AST_SLOT_NOT_CHAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_active && instr_valid) |=> !slot_active); // R9
    AST_SLOT_ENTRY_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_active) |-> (pc_out == $past(pc_out) + INSTR_BYTES)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(pc_out) && $stable(slot_active) && $stable(loop_bit))); // R12
    AST_NONLOOP_KEEPS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !loop_we) |=> $stable(loop_bit)); // R10
    AST_FALLTHROUGH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !slot_active && !taken) |=> (pc_out == $past(pc_out) + INSTR_BYTES)); // R2
endmodule

// File: tb/dbr_unit_bench.sv
module dbr_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] START_PC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0, rs1_val = '0, rs2_val = '0;
    logic        cc_in = 1'b0;
    logic [31:0] pc_out, next_pc, link_data, loop_data;
    logic        slot_active, link_we, loop_we, loop_bit;

    int errors = 0;
    int checks = 0;

    // reference model state
    logic [31:0] m_pc = START_PC;
    logic [31:0] m_pend = START_PC;
    logic        m_slot = 1'b0;
    logic        m_lcc = 1'b0;
    logic [31:0] e_next, e_link_data, e_loop_data;
    logic        e_link_we, e_loop_we, e_lcc_new;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbr_unit #(.RESET_PC(START_PC)) u_dbr_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .cc_in(cc_in),
        .pc_out(pc_out), .next_pc(next_pc), .slot_active(slot_active),
        .link_we(link_we), .link_data(link_data), .loop_we(loop_we),
        .loop_data(loop_data), .loop_bit(loop_bit)
    );

    task automatic check32(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_long(input logic [5:0] op, input int words);
        logic [31:0] w;
        w = words;
        return {op, w[25:0]};
    endfunction

    function automatic logic [31:0] mk_short(input logic [5:0] op, input logic [4:0] k,
                                             input int words);
        logic [31:0] w;
        w = words;
        return {op, 5'd0, w[15:11], k, w[10:0]};
    endfunction

    // behavioural evaluation of one instruction against the model state
    task automatic model_eval(input logic [31:0] iw, input logic [31:0] a,
                              input logic [31:0] b, input logic c, input logic v);
        int op;
        logic tk, slt, indirect;
        logic [31:0] tgt, lhs;
        longint unsigned wide;
        longint so, sl;
        op = int'(iw[31:26]);
        tk = 0; slt = 0; indirect = 0;
        so = longint'($signed(iw[25:0])) * 4;
        sl = longint'($signed({iw[20:16], iw[10:0]})) * 4;
        lhs = iw[26] ? {27'd0, iw[15:11]} : a;
        e_link_we = 0;
        e_loop_we = 0;
        case (op)
            'h10: begin tk = 1; slt = 1; indirect = 1; end
            'h13: if (iw[4:0] == 5'd2) begin tk = 1; slt = 1; indirect = 1; e_link_we = 1; end
            'h1A: begin tk = 1; slt = 1; sl = so; end
            'h1B: begin tk = 1; slt = 1; sl = so; e_link_we = 1; end
            'h1C: begin tk = c; sl = so; end
            'h1D: begin tk = c; slt = 1; sl = so; end
            'h1E: begin tk = !c; sl = so; end
            'h1F: begin tk = !c; slt = 1; sl = so; end
            'h14, 'h15: tk = (lhs != b);
            'h16, 'h17: tk = (lhs == b);
            'h2D: begin tk = m_lcc; slt = 1; e_loop_we = 1; end
            default: ;
        endcase
        tgt = indirect ? a : 32'(longint'(m_pc) + 4 + sl);
        wide = longint'(a) + longint'(b);
        e_loop_data = wide[31:0];
        e_lcc_new = $signed(a) < 0 ? ($signed(wide[31:0]) >= 0) : wide[32];
        e_link_data = m_pc + 8;
        if (!v) begin
            e_link_we = 0;
            e_loop_we = 0;
            e_next = m_pc;
        end else if (m_slot) begin
            e_next = tk ? tgt : m_pend;
        end else if (tk) begin
            e_next = slt ? m_pc + 4 : tgt;
        end else begin
            e_next = m_pc + 4;
        end
        if (v && !m_slot && tk && slt) m_pend = tgt;
        if (v) m_slot = !m_slot && tk && slt;
    endtask

    task automatic step(input string tag, input logic v, input logic [31:0] iw,
                        input logic [31:0] a, input logic [31:0] b, input logic c);
        @(negedge clk);
        instr_valid = v; instr = iw; rs1_val = a; rs2_val = b; cc_in = c;
        #1;
        model_eval(iw, a, b, c, v);
        check32(tag, "next_pc", next_pc, e_next);
        check32(tag, "link_we", {31'd0, link_we}, {31'd0, e_link_we});
        if (e_link_we) check32(tag, "link_data", link_data, e_link_data);
        check32(tag, "loop_we", {31'd0, loop_we}, {31'd0, e_loop_we});
        if (e_loop_we) check32(tag, "loop_data", loop_data, e_loop_data);
        @(posedge clk);
        m_pc = e_next;
        if (e_loop_we) m_lcc = e_lcc_new;
        #1;
        check32(tag, "pc_out", pc_out, m_pc);
        check32(tag, "slot_active", {31'd0, slot_active}, {31'd0, m_slot});
        check32(tag, "loop_bit", {31'd0, loop_bit}, {31'd0, m_lcc});
    endtask

    localparam logic [31:0] NOP = 32'h0000_0000;

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check32("R1", "pc_out", pc_out, START_PC);
        check32("R1", "slot_active", {31'd0, slot_active}, 32'd0);
        check32("R1", "loop_bit", {31'd0, loop_bit}, 32'd0);

        step("R2", 1, NOP, 32'h5, 32'h6, 0);
        step("R2", 1, 32'h2000_0003, 0, 0, 1);
        // R3 / R8: jump forward with slot
        step("R3", 1, mk_long(6'h1A, 5), 0, 0, 0);
        step("R8", 1, NOP, 0, 0, 0);
        // R4: call backward, link written
        step("R4", 1, mk_long(6'h1B, -3), 0, 0, 0);
        step("R8", 1, NOP, 0, 0, 0);
        // R6: conditional forms
        step("R6", 1, mk_long(6'h1C, 2), 0, 0, 1);
        step("R6", 1, mk_long(6'h1C, 2), 0, 0, 0);
        step("R6", 1, mk_long(6'h1D, -2), 0, 0, 1);
        step("R6", 1, NOP, 0, 0, 0);
        step("R6", 1, mk_long(6'h1E, 4), 0, 0, 1);
        step("R6", 1, mk_long(6'h1E, 4), 0, 0, 0);
        step("R6", 1, mk_long(6'h1F, 1), 0, 0, 0);
        step("R6", 1, NOP, 0, 0, 1);
        step("R6", 1, mk_long(6'h1F, 1), 0, 0, 1);
        // R5: indirect jump and indirect call
        step("R5", 1, {6'h10, 26'd0}, 32'h0000_4000, 0, 0);
        step("R5", 1, NOP, 0, 0, 0);
        step("R5", 1, {6'h13, 21'd0, 5'd2}, 32'h0000_5100, 0, 0);
        step("R4", 1, NOP, 0, 0, 0);
        step("R2", 1, {6'h13, 21'd0, 5'd4}, 32'h0000_7000, 0, 0);
        // R7: compare-and-branch
        step("R7", 1, mk_short(6'h15, 5'd7, 9), 0, 32'd7, 0);
        step("R7", 1, mk_short(6'h15, 5'd7, 9), 0, 32'd8, 0);
        step("R7", 1, mk_short(6'h16, 5'd0, -20), 32'h1234, 32'h1234, 0);
        step("R7", 1, mk_short(6'h16, 5'd0, -20), 32'h1234, 32'h1235, 0);
        step("R7", 1, mk_short(6'h14, 5'd3, 100), 32'd3, 32'd3, 0);
        step("R7", 1, mk_short(6'h17, 5'd31, -1), 0, 32'd31, 0);
        // R10 / R11: loop instruction
        step("R10", 1, mk_short(6'h2D, 5'd0, 6), 32'd1, 32'hFFFF_FFFF, 0);
        step("R10", 1, mk_short(6'h2D, 5'd0, 6), 32'hFFFF_FFFF, 32'd5, 0);
        step("R10", 1, NOP, 0, 0, 0);
        step("R11", 1, mk_short(6'h2D, 5'd0, -4), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        step("R11", 1, NOP, 0, 0, 0);
        step("R11", 1, mk_short(6'h2D, 5'd0, -4), 32'd2, 32'd3, 0);
        step("R11", 1, mk_short(6'h2D, 5'd0, 3), 32'h8000_0000, 32'h8000_0000, 0);
        // R9: branch inside a delay slot overrides the pending target
        step("R9", 1, mk_long(6'h1A, 40), 0, 0, 0);
        step("R9", 1, mk_long(6'h1C, -8), 0, 0, 1);
        step("R9", 1, mk_long(6'h1A, 12), 0, 0, 0);
        step("R9", 1, mk_long(6'h1D, 3), 0, 0, 0);
        step("R9", 1, NOP, 0, 0, 0);
        step("R10", 1, mk_short(6'h2D, 5'd0, 2), 32'd1, 32'hFFFF_FFFF, 0);
        step("R9", 1, mk_long(6'h1A, 30), 0, 0, 0);
        step("R9", 1, mk_short(6'h2D, 5'd0, -10), 32'd4, 32'd4, 0);
        step("R9", 1, NOP, 0, 0, 0);
        // R12: idle cycles, including while a slot is pending
        step("R12", 0, mk_long(6'h1A, 7), 0, 0, 1);
        step("R12", 1, mk_long(6'h1A, 7), 0, 0, 0);
        step("R12", 0, mk_short(6'h2D, 5'd0, 1), 32'd1, 32'hFFFF_FFFF, 0);
        step("R12", 0, {6'h13, 21'd0, 5'd2}, 32'h9000, 0, 0);
        step("R12", 1, NOP, 0, 0, 0);
        step("R2", 1, NOP, 0, 0, 0);

        @(negedge clk);
        instr_valid = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule